// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block tells the instruction decoder of a hypervisor-capable core which privileged and state-dependent instruction classes must trap, and with which cause. From the current privilege mode and a small set of control fields, it produces three results. The first is a per-class illegal-instruction flag. The second is a per-class virtual-instruction flag. The third is a single indication that a cache-block invalidate must run as a flush instead.

The control fields are the trap-virtual-memory and timeout-wait bits of the status register, their virtual-mode counterparts, the user-hypervisor-access bit, the floating-point and vector context states, the rounding-mode field and the cache-block enables at machine, hypervisor and supervisor environment level. The rules are pure combinational logic. An output stage, chosen by parameter, either registers the flags for one cycle or passes them straight through. The decoder samples the flags every cycle. The block does not decode instructions, enter traps or store control registers.

Top module: `privflag_check`

## Requirements
- R1: The mode is `virtMode` plus a 2-bit `privLvl`: level 11 is M (virtMode ignored), level 01 is HS (virtMode=0) or VS (virtMode=1), and levels 00 and 10 are HU (virtMode=0) or VU (virtMode=1). With REG_OUT=1 every output reflects the inputs of the previous clock edge, and all outputs are 0 while `rstN` is low.
- R2: `illFlags[0]` (address-translation fence) and `illFlags[2]` (guest-physical fence) are set in HS with tvm=1 or in HU. `virtFlags[0]` (address-translation fence) is set in VS with vtvm=1 or in VU. HS never raises any virtual flag.
- R3: `illFlags[1]` (partial fence/invalidate) and `illFlags[3]` (guest-virtual fence) are set only in HU. `virtFlags[1]` (partial fence) is set in VU. `virtFlags[2]` (any hypervisor fence) is set in VS or VU.
- R4: `illFlags[4]` (hypervisor load/store) is set in HU when hypUser=0. `virtFlags[3]` is set in VS or VU.
- R5: `illFlags[5]` is set when `fpState` is Off (00), and `illFlags[6]` when `vecState` is Off (00), in every mode.
- R6: `illFlags[8]` is set exactly when `frmVal` is greater than FRM_MAX (4), in every mode.
- R7: `illFlags[7]` (wait-for-interrupt) is set in HU, or in any non-M mode with tw=1. `virtFlags[4]` is set in VU with tw=0, or in VS with tw=0 and vtw=1.
- R8: For cache-block zero, `envZeroEn` holds bit0 machine, bit1 hypervisor and bit2 supervisor. `illFlags[9]` is set outside M when the machine bit is 0, or in HU when the supervisor bit is 0. `virtFlags[5]` is set when the machine bit is 1 and either VS has the hypervisor bit 0, or VU has the hypervisor or supervisor bit 0.
- R9: Cache-block clean/flush follows the same rule as R8 using `envCleanEn` (same bit order), with results on `illFlags[10]` and `virtFlags[6]`.
- R10: `envInvalCfg` holds three 2-bit fields, [1:0] machine, [3:2] hypervisor and [5:4] supervisor, coded Off=00, Flush=01, Invalidate=11. `illFlags[11]` is set outside M when the machine field is Off, or in HU when the supervisor field is Off. `virtFlags[7]` is set when the machine field is not Off and either VS has the hypervisor field Off, or VU has the hypervisor or supervisor field Off.
- R11: `invalAsFlush` is set when one of these holds:
  - HS and the machine field is Flush.
  - HU and the machine or supervisor field is Flush.
  - VS and the machine or hypervisor field is Flush.
  - VU and any of the three fields is Flush.
  It is never set in M.
- R12: A class never has both its illegal and its virtual flag set; the illegal flag takes priority. In M mode, all flags other than `illFlags[5]`, `illFlags[6]` and `illFlags[8]` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset |
| virtMode | input | 1 | Virtualization mode bit |
| privLvl | input | 2 | Privilege level (11 M, 01 S, else U) |
| tvm | input | 1 | Trap virtual-memory operations (status) |
| tw | input | 1 | Timeout wait (status) |
| vtvm | input | 1 | Trap virtual-memory operations in VS |
| vtw | input | 1 | Timeout wait in VS |
| hypUser | input | 1 | Allow hypervisor load/store in HU |
| fpState | input | ST_W | Floating-point context state, 00 = Off |
| vecState | input | ST_W | Vector context state, 00 = Off |
| frmVal | input | FRM_W | Dynamic rounding-mode field |
| envZeroEn | input | 3 | Cache-block zero enables {S,H,M} |
| envCleanEn | input | 3 | Cache-block clean/flush enables {S,H,M} |
| envInvalCfg | input | 6 | Cache-block invalidate fields {S,H,M} |
| illFlags | output | 12 | Illegal-instruction flags per class |
| virtFlags | output | 8 | Virtual-instruction flags per class |
| invalAsFlush | output | 1 | Perform invalidate as flush |

## Verification
With the default REG_OUT=1, every flag is due exactly one rising edge after its inputs are applied. The bench drives a vector on a falling edge and compares all 21 output bits on the next falling edge, which is exactly one edge later. It then applies the next vector at that same falling edge, so each vector takes one cycle. The assertion checker keeps its own one-cycle copy of the inputs and compares that copy with the registered outputs. This keeps cause and effect aligned without looking through the design's internals.

// File: rtl/privflag_pkg.sv
package privflag_pkg;
  localparam int ILL_N  = 12;
  localparam int VIRT_N = 8;
  localparam int LVL_N  = 3;  // machine, hypervisor, supervisor
  localparam int CBI_W  = 2;

  // illegal-instruction class positions
  localparam int IL_SFVMA = 0;
  localparam int IL_SFPRT = 1;
  localparam int IL_HFGV  = 2;
  localparam int IL_HFVV  = 3;
  localparam int IL_HLSV  = 4;
  localparam int IL_FPOFF = 5;
  localparam int IL_VCOFF = 6;
  localparam int IL_WFI   = 7;
  localparam int IL_FRM   = 8;
  localparam int IL_CBZ   = 9;
  localparam int IL_CBCF  = 10;
  localparam int IL_CBI   = 11;

  // virtual-instruction class positions
  localparam int VI_SFVMA = 0;
  localparam int VI_SFPRT = 1;
  localparam int VI_HFNC  = 2;
  localparam int VI_HLSV  = 3;
  localparam int VI_WFI   = 4;
  localparam int VI_CBZ   = 5;
  localparam int VI_CBCF  = 6;
  localparam int VI_CBI   = 7;

  localparam int LV_M = 0;
  localparam int LV_H = 1;
  localparam int LV_S = 2;

  typedef enum logic [CBI_W-1:0] {
    CBI_OFF   = 2'b00,
    CBI_FLUSH = 2'b01,
    CBI_RSVD  = 2'b10,
    CBI_INVAL = 2'b11
  } cbiMode_e;

  typedef struct packed {
    logic isM;
    logic isHS;
    logic isHU;
    logic isVS;
    logic isVU;
  } modeStrobe_t;
endpackage

// File: rtl/privflag_mode_ctrl.sv
module privflag_mode_ctrl
  import privflag_pkg::*;
(
  input  logic        virtMode,
  input  logic [1:0]  privLvl,
  output modeStrobe_t strobes
);
  logic lvlM, lvlS, lvlU;

  always_comb begin
    lvlM = (privLvl == 2'b11);
    lvlS = (privLvl == 2'b01);
    lvlU = !lvlM && !lvlS;
    strobes.isM  = lvlM;
    strobes.isHS = !virtMode && lvlS;
    strobes.isHU = !virtMode && lvlU;
    strobes.isVS = virtMode && lvlS;
    strobes.isVU = virtMode && lvlU;
  end
endmodule

// File: rtl/privflag_rule_dp.sv
module privflag_rule_dp
  import privflag_pkg::*;
#(
  parameter int ST_W    = 2,
  parameter int FRM_W   = 3,
  parameter int FRM_MAX = 4
) (
  input  modeStrobe_t              strobes,
  input  logic                     tvm,
  input  logic                     tw,
  input  logic                     vtvm,
  input  logic                     vtw,
  input  logic                     hypUser,
  input  logic [ST_W-1:0]          fpState,
  input  logic [ST_W-1:0]          vecState,
  input  logic [FRM_W-1:0]         frmVal,
  input  logic [LVL_N-1:0]         envZeroEn,
  input  logic [LVL_N-1:0]         envCleanEn,
  input  logic [LVL_N*CBI_W-1:0]   envInvalCfg,
  output logic [ILL_N-1:0]         illRaw,
  output logic [VIRT_N-1:0]        virtRaw,
  output logic                     flushRaw
);
  localparam logic [FRM_W-1:0] FRM_LIMIT = FRM_W'(FRM_MAX);

  logic [LVL_N-1:0] cbiOff;
  logic [LVL_N-1:0] cbiFlush;

  for (genvar g = 0; g < LVL_N; g++) begin : g_cbiLvl
    logic [CBI_W-1:0] fieldVal;
    assign fieldVal    = envInvalCfg[g*CBI_W +: CBI_W];
    assign cbiOff[g]   = (fieldVal == CBI_OFF);
    assign cbiFlush[g] = (fieldVal == CBI_FLUSH);
  end

  logic [ILL_N-1:0]  ill;
  logic [VIRT_N-1:0] vir;
  logic              nonM;

  always_comb begin
    nonM = !strobes.isM;
    ill  = '0;
    vir  = '0;

    ill[IL_SFVMA] = (strobes.isHS && tvm) || strobes.isHU;
    ill[IL_HFGV]  = (strobes.isHS && tvm) || strobes.isHU;
    ill[IL_SFPRT] = strobes.isHU;
    ill[IL_HFVV]  = strobes.isHU;
    ill[IL_HLSV]  = strobes.isHU && !hypUser;
    ill[IL_FPOFF] = (fpState == '0);
    ill[IL_VCOFF] = (vecState == '0);
    ill[IL_WFI]   = strobes.isHU || (nonM && tw);
    ill[IL_FRM]   = (frmVal > FRM_LIMIT);
    ill[IL_CBZ]   = (nonM && !envZeroEn[LV_M]) || (strobes.isHU && !envZeroEn[LV_S]);
    ill[IL_CBCF]  = (nonM && !envCleanEn[LV_M]) || (strobes.isHU && !envCleanEn[LV_S]);
    ill[IL_CBI]   = (nonM && cbiOff[LV_M]) || (strobes.isHU && cbiOff[LV_S]);

    vir[VI_SFVMA] = (strobes.isVS && vtvm) || strobes.isVU;
    vir[VI_SFPRT] = strobes.isVU;
    vir[VI_HFNC]  = strobes.isVS || strobes.isVU;
    vir[VI_HLSV]  = strobes.isVS || strobes.isVU;
    vir[VI_WFI]   = !tw && (strobes.isVU || (strobes.isVS && vtw));
    vir[VI_CBZ]   = envZeroEn[LV_M] &&
                    ((strobes.isVS && !envZeroEn[LV_H]) ||
                     (strobes.isVU && !(envZeroEn[LV_H] && envZeroEn[LV_S])));
    vir[VI_CBCF]  = envCleanEn[LV_M] &&
                    ((strobes.isVS && !envCleanEn[LV_H]) ||
                     (strobes.isVU && !(envCleanEn[LV_H] && envCleanEn[LV_S])));
    vir[VI_CBI]   = !cbiOff[LV_M] &&
                    ((strobes.isVS && cbiOff[LV_H]) ||
                     (strobes.isVU && (cbiOff[LV_H] || cbiOff[LV_S])));

    // illegal wins over virtual within a class
    virtRaw = vir;
    virtRaw[VI_SFVMA] = vir[VI_SFVMA] && !ill[IL_SFVMA];
    virtRaw[VI_SFPRT] = vir[VI_SFPRT] && !ill[IL_SFPRT];
    virtRaw[VI_HFNC]  = vir[VI_HFNC]  && !(ill[IL_HFGV] || ill[IL_HFVV]);
    virtRaw[VI_HLSV]  = vir[VI_HLSV]  && !ill[IL_HLSV];
    virtRaw[VI_WFI]   = vir[VI_WFI]   && !ill[IL_WFI];
    virtRaw[VI_CBZ]   = vir[VI_CBZ]   && !ill[IL_CBZ];
    virtRaw[VI_CBCF]  = vir[VI_CBCF]  && !ill[IL_CBCF];
    virtRaw[VI_CBI]   = vir[VI_CBI]   && !ill[IL_CBI];
    illRaw = ill;

    flushRaw = (strobes.isHS && cbiFlush[LV_M]) ||
               (strobes.isHU && (cbiFlush[LV_M] || cbiFlush[LV_S])) ||
               (strobes.isVS && (cbiFlush[LV_M] || cbiFlush[LV_H])) ||
               (strobes.isVU && (|cbiFlush));
  end
endmodule

// File: rtl/privflag_out_stage.sv
module privflag_out_stage #(
  parameter int W       = 21,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] qOut
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) qOut <= '0;
      else       qOut <= dIn;
    end
  end else begin : g_pass
    assign qOut = dIn;
  end
endmodule

// File: rtl/privflag_check.sv
module privflag_check
  import privflag_pkg::*;
#(
  parameter int ST_W    = 2,
  parameter int FRM_W   = 3,
  parameter int FRM_MAX = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   virtMode,
  input  logic [1:0]             privLvl,
  input  logic                   tvm,
  input  logic                   tw,
  input  logic                   vtvm,
  input  logic                   vtw,
  input  logic                   hypUser,
  input  logic [ST_W-1:0]        fpState,
  input  logic [ST_W-1:0]        vecState,
  input  logic [FRM_W-1:0]       frmVal,
  input  logic [2:0]             envZeroEn,
  input  logic [2:0]             envCleanEn,
  input  logic [5:0]             envInvalCfg,
  output logic [11:0]            illFlags,
  output logic [7:0]             virtFlags,
  output logic                   invalAsFlush
);
  localparam int OUT_W = ILL_N + VIRT_N + 1;

  modeStrobe_t       strobes;
  logic [ILL_N-1:0]  illRaw;
  logic [VIRT_N-1:0] virtRaw;
  logic              flushRaw;
  logic [OUT_W-1:0]  packedOut;

  privflag_mode_ctrl u_modeCtrl (
    .virtMode (virtMode),
    .privLvl  (privLvl),
    .strobes  (strobes)
  );

  privflag_rule_dp #(
    .ST_W    (ST_W),
    .FRM_W   (FRM_W),
    .FRM_MAX (FRM_MAX)
  ) u_ruleDp (
    .strobes     (strobes),
    .tvm         (tvm),
    .tw          (tw),
    .vtvm        (vtvm),
    .vtw         (vtw),
    .hypUser     (hypUser),
    .fpState     (fpState),
    .vecState    (vecState),
    .frmVal      (frmVal),
    .envZeroEn   (envZeroEn),
    .envCleanEn  (envCleanEn),
    .envInvalCfg (envInvalCfg),
    .illRaw      (illRaw),
    .virtRaw     (virtRaw),
    .flushRaw    (flushRaw)
  );

  privflag_out_stage #(
    .W       (OUT_W),
    .REG_OUT (REG_OUT)
  ) u_outStage (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({flushRaw, virtRaw, illRaw}),
    .qOut (packedOut)
  );

  assign illFlags     = packedOut[ILL_N-1:0];
  assign virtFlags    = packedOut[ILL_N +: VIRT_N];
  assign invalAsFlush = packedOut[OUT_W-1];
endmodule

// File: rtl/privflag_check_sva.sv
module privflag_check_sva #(
  parameter int ST_W    = 2,
  parameter int FRM_W   = 3,
  parameter int FRM_MAX = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             virtMode,
  input logic [1:0]       privLvl,
  input logic [ST_W-1:0]  fpState,
  input logic [FRM_W-1:0] frmVal,
  input logic [11:0]      illFlags,
  input logic [7:0]       virtFlags,
  input logic             invalAsFlush
);
  logic             seenOk;
  logic             seenVirt;
  logic [1:0]       seenLvl;
  logic [ST_W-1:0]  seenFp;
  logic [FRM_W-1:0] seenFrm;

  if (REG_OUT) begin : g_delay
    always_ff @(posedge clk) begin
      if (!rstN) begin
        seenOk   <= 1'b0;
        seenVirt <= 1'b0;
        seenLvl  <= 2'b11;
        seenFp   <= '1;
        seenFrm  <= '0;
      end else begin
        seenOk   <= 1'b1;
        seenVirt <= virtMode;
        seenLvl  <= privLvl;
        seenFp   <= fpState;
        seenFrm  <= frmVal;
      end
    end
  end else begin : g_direct
    assign seenOk   = 1'b1;
    assign seenVirt = virtMode;
    assign seenLvl  = privLvl;
    assign seenFp   = fpState;
    assign seenFrm  = frmVal;
  end

  logic wasM, wasHS, wasHU;
  assign wasM  = (seenLvl == 2'b11);
  assign wasHS = !seenVirt && (seenLvl == 2'b01);
  assign wasHU = !seenVirt && (seenLvl[0] == 1'b0);

  // R12: illegal and virtual never both set for one class
  p_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((illFlags[0] & virtFlags[0]) | (illFlags[1] & virtFlags[1]) |
     ((illFlags[2] | illFlags[3]) & virtFlags[2]) | (illFlags[4] & virtFlags[3]) |
     (illFlags[7] & virtFlags[4]) | (illFlags[9] & virtFlags[5]) |
     (illFlags[10] & virtFlags[6]) | (illFlags[11] & virtFlags[7])) == 1'b0);

  // R12: M mode only reports context-off and rounding-mode flags
  p_msilent_r12: assert property (@(posedge clk) disable iff (!rstN || !seenOk)
    wasM |-> ((illFlags & 12'hE9F) == 12'h0) && (virtFlags == 8'h0));

  // R11: no invalidate-as-flush in M mode
  p_noflush_m_r11: assert property (@(posedge clk) disable iff (!rstN || !seenOk)
    wasM |-> !invalAsFlush);

  // R2: HS mode never raises a virtual flag
  p_hsnovirt_r2: assert property (@(posedge clk) disable iff (!rstN || !seenOk)
    wasHS |-> (virtFlags == 8'h0));

  // R6: reserved rounding mode flag follows the value range
  p_frm_r6: assert property (@(posedge clk) disable iff (!rstN || !seenOk)
    illFlags[8] == (seenFrm > FRM_W'(FRM_MAX)));

  // R5: floating-point state Off always raises its flag
  p_fpoff_r5: assert property (@(posedge clk) disable iff (!rstN || !seenOk)
    (seenFp == '0) |-> illFlags[5]);

  // R7 and R3: HU mode always flags wait and the HU-only fences
  p_hu_r7: assert property (@(posedge clk) disable iff (!rstN || !seenOk)
    wasHU |-> (illFlags[7] && illFlags[1] && illFlags[3]));
endmodule

bind privflag_check privflag_check_sva #(
  .ST_W    (ST_W),
  .FRM_W   (FRM_W),
  .FRM_MAX (FRM_MAX),
  .REG_OUT (REG_OUT)
) u_sva (
  .clk          (clk),
  .rstN         (rstN),
  .virtMode     (virtMode),
  .privLvl      (privLvl),
  .fpState      (fpState),
  .frmVal       (frmVal),
  .illFlags     (illFlags),
  .virtFlags    (virtFlags),
  .invalAsFlush (invalAsFlush)
);

// File: tb/privflag_check_bench.sv
`timescale 1ns/1ps
module privflag_check_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        virtMode = 1'b0;
  logic [1:0]  privLvl = 2'b11;
  logic        tvm = 1'b0, tw = 1'b0, vtvm = 1'b0, vtw = 1'b0, hypUser = 1'b0;
  logic [1:0]  fpState = 2'b00, vecState = 2'b00;
  logic [2:0]  frmVal = 3'd7;
  logic [2:0]  envZeroEn = 3'b000, envCleanEn = 3'b000;
  logic [5:0]  envInvalCfg = 6'b010101;
  logic [11:0] illFlags;
  logic [7:0]  virtFlags;
  logic        invalAsFlush;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  privflag_check u_privflag_check (
    .clk(clk), .rstN(rstN), .virtMode(virtMode), .privLvl(privLvl),
    .tvm(tvm), .tw(tw), .vtvm(vtvm), .vtw(vtw), .hypUser(hypUser),
    .fpState(fpState), .vecState(vecState), .frmVal(frmVal),
    .envZeroEn(envZeroEn), .envCleanEn(envCleanEn), .envInvalCfg(envInvalCfg),
    .illFlags(illFlags), .virtFlags(virtFlags), .invalAsFlush(invalAsFlush)
  );

  function automatic string reqOf(input int bitIdx);
    // bitIdx 0..11 illegal, 12..19 virtual, 20 flush
    case (bitIdx)
      0, 2, 12:  return "R2";
      1, 3, 13, 14: return "R3";
      4, 15:     return "R4";
      5, 6:      return "R5";
      8:         return "R6";
      7, 16:     return "R7";
      9, 17:     return "R8";
      10, 18:    return "R9";
      11, 19:    return "R10";
      default:   return "R11";
    endcase
  endfunction

  function automatic logic [20:0] expect_out();
    logic m, hs, hu, vs, vu, nm;
    logic [11:0] e;
    logic [7:0]  v;
    logic [2:0]  off, fl;
    logic        f;
    m  = (privLvl == 2'd3);
    hs = !virtMode && privLvl == 2'd1;
    vs = virtMode && privLvl == 2'd1;
    hu = !virtMode && (privLvl == 2'd0 || privLvl == 2'd2);
    vu = virtMode && (privLvl == 2'd0 || privLvl == 2'd2);
    nm = !m;
    for (int i = 0; i < 3; i++) begin
      off[i] = envInvalCfg[2*i +: 2] == 2'b00;
      fl[i]  = envInvalCfg[2*i +: 2] == 2'b01;
    end
    e = '0; v = '0;
    e[0] = hu | (hs & tvm);  e[2] = e[0];
    e[1] = hu;               e[3] = hu;
    e[4] = hu & ~hypUser;
    e[5] = fpState == 2'b00; e[6] = vecState == 2'b00;
    e[7] = hu | (nm & tw);
    e[8] = frmVal >= 3'd5;
    e[9]  = (nm & ~envZeroEn[0]) | (hu & ~envZeroEn[2]);
    e[10] = (nm & ~envCleanEn[0]) | (hu & ~envCleanEn[2]);
    e[11] = (nm & off[0]) | (hu & off[2]);
    v[0] = vu | (vs & vtvm);
    v[1] = vu;
    v[2] = vs | vu;
    v[3] = vs | vu;
    v[4] = ~tw & (vu | (vs & vtw));
    v[5] = envZeroEn[0] & ((vs & ~envZeroEn[1]) | (vu & (~envZeroEn[1] | ~envZeroEn[2])));
    v[6] = envCleanEn[0] & ((vs & ~envCleanEn[1]) | (vu & (~envCleanEn[1] | ~envCleanEn[2])));
    v[7] = ~off[0] & ((vs & off[1]) | (vu & (off[1] | off[2])));
    // R12: illegal wins
    if (e[0]) v[0] = 1'b0;
    if (e[1]) v[1] = 1'b0;
    if (e[2] | e[3]) v[2] = 1'b0;
    if (e[4]) v[3] = 1'b0;
    if (e[7]) v[4] = 1'b0;
    if (e[9]) v[5] = 1'b0;
    if (e[10]) v[6] = 1'b0;
    if (e[11]) v[7] = 1'b0;
    f = (hs & fl[0]) | (hu & (fl[0] | fl[2])) | (vs & (fl[0] | fl[1])) | (vu & (|fl));
    return {f, v, e};
  endfunction

  // inputs were set on the previous falling edge; output due one rising edge later
  task automatic step_and_check();
    logic [20:0] exp_v, act_v, diff;
    exp_v = expect_out();
    @(negedge clk);
    act_v = {invalAsFlush, virtFlags, illFlags};
    checks++;
    diff = exp_v ^ act_v;
    if (diff != 0) begin
      int b = 0;
      for (int i = 20; i >= 0; i--) if (diff[i]) b = i;
      fails++;
      $display("FAIL %s bit %0d: actual %h expected %h (virt=%0b lvl=%0d)",
               reqOf(b), b, act_v, exp_v, virtMode, privLvl);
    end
    // R12: M mode silence and exclusivity at the ports
    if (privLvl == 2'd3) begin
      checks++;
      if ((illFlags & 12'hE9F) != 0 || virtFlags != 0 || invalAsFlush) begin
        fails++;
        $display("FAIL R12 M mode: actual %h expected %h", act_v,
                 {1'b0, 8'h00, illFlags & 12'h160});
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R1 watchdog expired: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    // R1: reset state, with inputs that would otherwise raise flags
    repeat (3) @(negedge clk);
    checks++;
    if (illFlags != 0 || virtFlags != 0 || invalAsFlush != 0) begin
      fails++;
      $display("FAIL R1 reset: actual %h expected 0", {invalAsFlush, virtFlags, illFlags});
    end
    rstN = 1'b1;

    // R1 R2 R3 R4 R5 R6 R7 R12: mode x trap-control bits x rounding mode x context states
    for (int md = 0; md < 8; md++)
      for (int c = 0; c < 32; c++)
        for (int f = 0; f < 8; f++)
          for (int k = 0; k < 4; k++) begin
            virtMode = md[2]; privLvl = md[1:0];
            {tvm, tw, vtvm, vtw, hypUser} = c[4:0];
            frmVal = f[2:0];
            fpState = k[1:0]; vecState = 2'(3 - k);
            envZeroEn = c[2:0]; envCleanEn = c[4:2];
            envInvalCfg = {c[1:0], c[3:2], 2'(f)};
            step_and_check();
          end

    // R8 R9 R10 R11: all environment enable and invalidate-field combinations
    tvm = 1'b0; tw = 1'b0; vtvm = 1'b0; vtw = 1'b0; hypUser = 1'b1;
    fpState = 2'b11; vecState = 2'b01; frmVal = 3'd0;
    for (int md = 0; md < 8; md++)
      for (int z = 0; z < 8; z++)
        for (int cl = 0; cl < 8; cl++)
          for (int ci = 0; ci < 64; ci++) begin
            virtMode = md[2]; privLvl = md[1:0];
            envZeroEn = z[2:0]; envCleanEn = cl[2:0]; envInvalCfg = ci[5:0];
            step_and_check();
          end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule